// File: doc/BRIEF.md
# Video Field Line Counter with Vertical Sync Lockout

This block counts video lines within a field and drives an active-low frame sync. A line strobe from the horizontal timing logic advances the count. A rising edge on the active-high vertical sync input restarts the field at line 0 and starts a frame sync pulse that is a fixed number of lines long. Once a field has started from a vertical sync, further vertical sync edges are ignored for a lockout window of lines, so that noise or equalising pulses cannot restart the field early.

When no vertical sync arrives, the counter wraps by itself after a field-length limit. A field started this way, or by the forced reset, carries no lockout, so the next real vertical sync is taken as soon as it arrives and the counter locks back on. The standard-select input picks both the lockout length and the wrap limit. In external-sync mode the frame sync comes from outside: it is sampled on each line strobe, passed to the output, and its falling edge restarts the count.

Top module: `vfield_counter`

## Requirements
- R1: While `frame_rst_n` is low, `line_cnt` is 0 and, in internal mode, `fsync_n` is 0 (low). The field that starts at release carries no lockout.
- R2: `line_cnt` rises by exactly one on each clock where `line_stb` is 1, and holds on clocks without a strobe, unless a restart applies.
- R3: In internal mode, `fsync_n` is 0 while `line_cnt` is below `PULSE_LINES` (3 by default) and 1 otherwise. Every restart therefore gives a low pulse of `PULSE_LINES` lines.
- R4: In internal mode, an accepted rising edge of `vsync_in` passes through a two-stage synchroniser. `line_cnt` reads 0 after the third rising clock edge that follows the change of `vsync_in` to 1.
- R5: In internal mode, a line strobe that arrives while `line_cnt` is at the wrap limit minus one sets `line_cnt` to 0. The wrap limit is `AUTO_NTSC` when `pal_sel` is 0 and `AUTO_PAL` when `pal_sel` is 1.
- R6: After a restart caused by `vsync_in`, rising edges of `vsync_in` are ignored while `line_cnt` is below the lockout length and accepted once `line_cnt` reaches it. The lockout length is `LOCK_NTSC` when `pal_sel` is 0 and `LOCK_PAL` when `pal_sel` is 1.
- R7: After a wrap restart or a forced reset, no lockout applies, and a rising edge of `vsync_in` is accepted at any `line_cnt`.
- R8: Only a rising edge of `vsync_in` restarts the field. Holding `vsync_in` high does not restart it again.
- R9: When `ext_mode` is 1, `vsync_in` is ignored and the wrap does not occur; the count instead saturates at its maximum. On each line strobe `ext_fsync_n` is sampled and `fsync_n` shows that sample. A sample of 0 that follows a sample of 1 sets `line_cnt` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| line_stb | input | 1 | Single-cycle strobe, one per video line |
| vsync_in | input | 1 | Vertical sync, active high, asynchronous |
| pal_sel | input | 1 | 0 selects NTSC lengths, 1 selects PAL lengths |
| frame_rst_n | input | 1 | Active-low forced reset of the field counter |
| ext_mode | input | 1 | 1 takes the frame sync from `ext_fsync_n` |
| ext_fsync_n | input | 1 | External frame sync, active low, sampled on line strobes |
| fsync_n | output | 1 | Frame sync, active low |
| line_cnt | output | CNT_W | Current line within the field |

## Verification
The bench builds the block with an 8-bit count, wrap limits of 20 and 26 lines, and lockout lengths of 8 and 11 lines. With these values the wrap in both standards, the last locked line and the first open line can all be reached within a few dozen strobes. The vector table places vertical sync edges on each side of both lockout boundaries. The directed tests cover the reset pulse, the wrap, the release of the lockout after a wrap, a held sync level, and external mode running past the wrap limit.

// File: rtl/vfield_counter.sv
module vfield_counter #(
  parameter int CNT_W       = 10,
  parameter int AUTO_NTSC   = 284,
  parameter int AUTO_PAL    = 344,
  parameter int LOCK_NTSC   = 192,
  parameter int LOCK_PAL    = 227,
  parameter int PULSE_LINES = 3
) (
  input  logic             clk,
  input  logic             line_stb,
  input  logic             vsync_in,
  input  logic             pal_sel,
  input  logic             frame_rst_n,
  input  logic             ext_mode,
  input  logic             ext_fsync_n,
  output logic             fsync_n,
  output logic [CNT_W-1:0] line_cnt
);

  localparam logic [CNT_W-1:0] WRAP_N  = CNT_W'(AUTO_NTSC - 1);
  localparam logic [CNT_W-1:0] WRAP_P  = CNT_W'(AUTO_PAL - 1);
  localparam logic [CNT_W-1:0] LOCK_N  = CNT_W'(LOCK_NTSC);
  localparam logic [CNT_W-1:0] LOCK_P  = CNT_W'(LOCK_PAL);
  localparam logic [CNT_W-1:0] PULSE_L = CNT_W'(PULSE_LINES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic vs_m, vs_s, vs_d;
  logic ext_q;
  logic auto_last;

  logic [CNT_W-1:0] wrap_at, lock_len;
  assign wrap_at  = pal_sel ? WRAP_P : WRAP_N;
  assign lock_len = pal_sel ? LOCK_P : LOCK_N;

  logic vs_rise, locked, take_vs, wrap, ext_fall;
  assign vs_rise  = vs_s & ~vs_d;
  assign locked   = ~auto_last & (line_cnt < lock_len);
  assign take_vs  = ~ext_mode & vs_rise & ~locked;
  assign wrap     = ~ext_mode & line_stb & (line_cnt >= wrap_at);
  assign ext_fall = ext_mode & line_stb & ext_q & ~ext_fsync_n;

  always_ff @(posedge clk or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      vs_m <= 1'b0;
      vs_s <= 1'b0;
      vs_d <= 1'b0;
    end else begin
      vs_m <= vsync_in;
      vs_s <= vs_m;
      vs_d <= vs_s;
    end
  end

  always_ff @(posedge clk or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      line_cnt  <= '0;
      auto_last <= 1'b1;
      ext_q     <= 1'b1;
    end else begin
      if (ext_mode && line_stb) ext_q <= ext_fsync_n;
      if (take_vs) begin
        line_cnt  <= '0;
        auto_last <= 1'b0;
      end else if (wrap) begin
        line_cnt  <= '0;
        auto_last <= 1'b1;
      end else if (ext_fall) begin
        line_cnt  <= '0;
      end else if (line_stb && line_cnt != CNT_MAX) begin
        line_cnt  <= line_cnt + 1'b1;
      end
    end
  end

  assign fsync_n = ext_mode ? ext_q : (line_cnt >= PULSE_L);

endmodule

// File: rtl/vfield_counter_chk.sv
module vfield_counter_chk #(
  parameter int CNT_W       = 10,
  parameter int AUTO_NTSC   = 284,
  parameter int AUTO_PAL    = 344,
  parameter int LOCK_NTSC   = 192,
  parameter int LOCK_PAL    = 227,
  parameter int PULSE_LINES = 3
) (
  input logic             clk,
  input logic             line_stb,
  input logic             vsync_in,
  input logic             pal_sel,
  input logic             frame_rst_n,
  input logic             ext_mode,
  input logic             ext_fsync_n,
  input logic             fsync_n,
  input logic [CNT_W-1:0] line_cnt
);

  logic [CNT_W-1:0] last_line;
  assign last_line = pal_sel ? CNT_W'(AUTO_PAL - 1) : CNT_W'(AUTO_NTSC - 1);

  // R1
  always @(posedge clk) begin
    if (frame_rst_n === 1'b0) begin
      rst_clear_chk: assert (line_cnt == '0);
    end
  end

  // R2
  cnt_move_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
    !$stable(line_cnt) |-> (line_cnt == '0 || $past(line_stb)));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
    ($past(line_stb) && !$past(ext_mode) && line_cnt != '0)
      |-> line_cnt == $past(line_cnt) + 1'b1);

  // R3
  fsync_start_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
    (!ext_mode && !$past(ext_mode) && $fell(fsync_n)) |-> line_cnt == '0);

  // R5
  auto_wrap_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
    (!ext_mode && line_stb && line_cnt == last_line) |=> line_cnt == '0);

  // R9
  ext_hold_chk: assert property (@(posedge clk) disable iff (!frame_rst_n)
    (ext_mode && $past(ext_mode) && !$past(line_stb)) |-> $stable(fsync_n));

endmodule

bind vfield_counter vfield_counter_chk #(
  .CNT_W(CNT_W), .AUTO_NTSC(AUTO_NTSC), .AUTO_PAL(AUTO_PAL),
  .LOCK_NTSC(LOCK_NTSC), .LOCK_PAL(LOCK_PAL), .PULSE_LINES(PULSE_LINES)
) u_chk (
  .clk(clk), .line_stb(line_stb), .vsync_in(vsync_in), .pal_sel(pal_sel),
  .frame_rst_n(frame_rst_n), .ext_mode(ext_mode), .ext_fsync_n(ext_fsync_n),
  .fsync_n(fsync_n), .line_cnt(line_cnt)
);

// File: tb/vfield_counter_tb.sv
module vfield_counter_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic line_stb = 1'b0, vsync_in = 1'b0, pal_sel = 1'b0;
  logic frame_rst_n = 1'b0, ext_mode = 1'b0, ext_fsync_n = 1'b1;
  logic fsync_n;
  logic [W-1:0] line_cnt;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vfield_counter #(.CNT_W(W), .AUTO_NTSC(20), .AUTO_PAL(26),
    .LOCK_NTSC(8), .LOCK_PAL(11), .PULSE_LINES(3)) u_dut (
    .clk(clk), .line_stb(line_stb), .vsync_in(vsync_in), .pal_sel(pal_sel),
    .frame_rst_n(frame_rst_n), .ext_mode(ext_mode), .ext_fsync_n(ext_fsync_n),
    .fsync_n(fsync_n), .line_cnt(line_cnt));

  // {pal_sel, lines before the sync edge[7:0], accepted}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 8'd7,  1'b0}, {1'b0, 8'd8,  1'b1}, {1'b0, 8'd3,  1'b0},
    {1'b0, 8'd15, 1'b1}, {1'b1, 8'd10, 1'b0}, {1'b1, 8'd11, 1'b1},
    {1'b1, 8'd8,  1'b0}, {1'b1, 8'd20, 1'b1}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) frame_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    frame_rst_n = 1'b1;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) line_stb = 1'b1;
      @(negedge clk) line_stb = 1'b0;
    end
  endtask

  task automatic vs_rise_only();
    @(negedge clk) vsync_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic vs_drop();
    vsync_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 cnt in reset", int'(line_cnt), 0);
    chk("R1 fsync in reset", int'(fsync_n), 0);
    frame_rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      do_reset();
      pal_sel = VEC[v][9];
      vs_rise_only(); vs_drop();
      chk("R4 vsync restart", int'(line_cnt), 0);
      strobe(int'(VEC[v][8:1]));
      vs_rise_only(); vs_drop();
      chk("R6 lockout edge", int'(line_cnt), VEC[v][0] ? 0 : int'(VEC[v][8:1]));
    end

    // R2 / R3 pulse and stepping
    pal_sel = 1'b0;
    do_reset();
    strobe(1);
    chk("R2 step", int'(line_cnt), 1);
    chk("R3 fsync low line1", int'(fsync_n), 0);
    repeat (5) @(negedge clk);
    chk("R2 hold without strobe", int'(line_cnt), 1);
    strobe(1);
    chk("R3 fsync low line2", int'(fsync_n), 0);
    strobe(1);
    chk("R3 fsync high line3", int'(fsync_n), 1);

    // R5 wrap NTSC, then R7 no lockout
    strobe(16);
    chk("R5 last ntsc line", int'(line_cnt), 19);
    strobe(1);
    chk("R5 ntsc wrap", int'(line_cnt), 0);
    chk("R3 fsync after wrap", int'(fsync_n), 0);
    strobe(2);
    chk("R7 count after wrap", int'(line_cnt), 2);
    vs_rise_only(); vs_drop();
    chk("R7 sync taken after wrap", int'(line_cnt), 0);

    // R5 wrap PAL
    do_reset();
    pal_sel = 1'b1;
    strobe(25);
    chk("R5 last pal line", int'(line_cnt), 25);
    strobe(1);
    chk("R5 pal wrap", int'(line_cnt), 0);

    // R7 after forced reset
    do_reset();
    strobe(1);
    vs_rise_only(); vs_drop();
    chk("R7 sync taken after reset", int'(line_cnt), 0);

    // R8 held level
    pal_sel = 1'b0;
    do_reset();
    vs_rise_only();
    strobe(10);
    chk("R8 held vsync no retrigger", int'(line_cnt), 10);
    vs_drop();
    chk("R8 after release", int'(line_cnt), 10);

    // R9 external mode
    do_reset();
    ext_mode = 1'b1;
    strobe(1);
    chk("R9 ext count", int'(line_cnt), 1);
    chk("R9 ext fsync high", int'(fsync_n), 1);
    vs_rise_only(); vs_drop();
    chk("R9 vsync ignored", int'(line_cnt), 1);
    ext_fsync_n = 1'b0;
    @(negedge clk);
    chk("R9 fsync waits for strobe", int'(fsync_n), 1);
    strobe(1);
    chk("R9 ext restart", int'(line_cnt), 0);
    chk("R9 ext fsync low", int'(fsync_n), 0);
    strobe(1);
    chk("R9 no second restart", int'(line_cnt), 1);
    ext_fsync_n = 1'b1;
    strobe(1);
    chk("R9 ext fsync high again", int'(fsync_n), 1);
    strobe(40);
    chk("R9 no wrap in ext mode", int'(line_cnt), 42);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule